// File: doc/BRIEF.md
# Performance Counter Group Register Block

This block is a bank of event counters that software controls through memory-mapped registers. Each counter has its own event selector. It counts when three things hold in the same cycle: its selected event is active, its own enable bit is set, and the global run bit is on. Event 0 counts every clock cycle. Events 1 through `NUM_EV` follow the strobe inputs. Software can preload any counter, for example to half of full scale, so that it overflows after a chosen number of events.

When a counter wraps from all ones to zero, it sets its overflow status bit. An interrupt line is raised while the interrupt output is enabled and some counter has both its overflow bit and its interrupt-enable bit set. Counter enable, interrupt enable and overflow status each have one address that sets bits and another that clears them, so software can change one counter without a read-modify-write. A read-only configuration word reports the counter count, the counter width and the filter mode. A stream-match word is stored for each counter so that software can read it back.

Top module: `perf_cnt_bank`

## Requirements
- R1: After reset, every counter, event selector, stream-match word, enable mask, overflow mask, run bit and interrupt-output enable is zero, `irq_o` is low and `rd_valid` is low.
- R2: A read request (`req_valid` high, `req_write` low) drives `rd_valid` high on the next cycle, with `rd_data` showing the register as it stood before that clock edge. Any other cycle leaves `rd_valid` low. A write takes effect at the clock edge on which it is presented.
- R3: A counter adds one on a cycle only when bit 0 of the run register (0xE04) is 1, its bit in the counter-enable mask is 1, and its selected event is active. Otherwise it holds its value.
- R4: Bits 15:0 of the event selector at 0x400 + 4·n choose the event. Value 0 is active on every cycle. Value k, for k from 1 to `NUM_EV`, follows `evt_i[k-1]`. Any larger value is never active. Bits 31:16 of the selector read as zero.
- R5: Counter n is read and written at n·4 when `CTR_W` ≤ 32. When `CTR_W` > 32 it sits at n·8, with bits 31:0 at the low word and the remaining upper bits at +4. A write replaces the addressed part of the counter, takes priority over an increment in the same cycle, and does not set overflow in that cycle.
- R6: Writing ones to 0xC00 sets counter-enable bits and writing ones to 0xC20 clears them. 0xC40 and 0xC60 do the same for the interrupt-enable mask. Bit n belongs to counter n. Reading either address of a pair returns the current mask.
- R7: A counter that increments from all ones sets its overflow bit and wraps to zero. Writing ones to 0xC80 clears overflow bits and writing ones to 0xCC0 sets them. Both addresses read the overflow mask. If a wrap and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when bit 0 of 0xE50 is 1 and at least one counter has both its overflow bit and its interrupt-enable bit set. It follows the register state in the cycle after the edge that changes that state.
- R9: The word at 0xE00 is read-only. It carries `NUM_CTR`−1 in bits 5:0, `CTR_W`−1 in bits 13:8 and `GLOBAL_FILTER` in bit 23, with all other bits zero.
- R10: The stream-match word at 0xA00 + 4·n is 32 bits of read/write storage and has no effect on counting.
- R11: Writes to counter, selector or stream-match slots with index ≥ `NUM_CTR` change nothing, and reads of them return zero. Mask bits at and above `NUM_CTR` are ignored on write and read as zero. Unmapped addresses read zero.
- R12: Only bit 0 of 0xE04 and 0xE50 is stored. Their other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| evt_i | input | NUM_EV | Event strobes; `evt_i[k-1]` is event k |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Register writes, counter increments and overflow updates all land on the clock edge at which they are presented. `irq_o` reflects that new state in the same cycle, so it is due one cycle after the stimulus. Read data is due one cycle after the request and carries the pre-edge state. The bench keeps a behavioural model that it advances at each rising edge from the same inputs. It then compares `irq_o`, `rd_valid` and `rd_data` a short delay after that edge, which lines every comparison up with the one-register latency of each path.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CEN_SET = 12'hC00;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 12'hC20;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 12'hC40;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 12'hC60;
  localparam logic [ADDR_W-1:0] A_OVF_CLR = 12'hC80;
  localparam logic [ADDR_W-1:0] A_OVF_SET = 12'hCC0;
  localparam logic [ADDR_W-1:0] A_CFG     = 12'hE00;
  localparam logic [ADDR_W-1:0] A_RUN     = 12'hE04;
  localparam logic [ADDR_W-1:0] A_IRQCTL  = 12'hE50;

  typedef enum logic [3:0] {
    K_NONE, K_CNT_LO, K_CNT_HI, K_EVT, K_SMR,
    K_CEN_SET, K_CEN_CLR, K_IEN_SET, K_IEN_CLR,
    K_OVF_SET, K_OVF_CLR, K_CFG, K_RUN, K_IRQCTL
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] idx;
  } dec_t;

  // Map a byte address to a register kind and a counter index.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input logic wide);
    dec_t d;
    logic [ADDR_W-1:0] w;
    w = {a[ADDR_W-1:2], 2'b00};
    d.kind = K_NONE;
    d.idx  = '0;
    if (a[11:10] == 2'b00) begin
      if (wide) begin
        d.kind = a[2] ? K_CNT_HI : K_CNT_LO;
        d.idx  = {1'b0, a[9:3]};
      end else begin
        d.kind = K_CNT_LO;
        d.idx  = a[9:2];
      end
    end else if (a[11:10] == 2'b01) begin
      d.kind = K_EVT;
      d.idx  = a[9:2];
    end else if (a[11:9] == 3'b101) begin
      d.kind = K_SMR;
      d.idx  = {1'b0, a[8:2]};
    end else begin
      case (w)
        A_CEN_SET: d.kind = K_CEN_SET;
        A_CEN_CLR: d.kind = K_CEN_CLR;
        A_IEN_SET: d.kind = K_IEN_SET;
        A_IEN_CLR: d.kind = K_IEN_CLR;
        A_OVF_SET: d.kind = K_OVF_SET;
        A_OVF_CLR: d.kind = K_OVF_CLR;
        A_CFG:     d.kind = K_CFG;
        A_RUN:     d.kind = K_RUN;
        A_IRQCTL:  d.kind = K_IRQCTL;
        default:   d.kind = K_NONE;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/pcb_setclr.sv
// Mask register with independent set and clear inputs; set dominates.
module pcb_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/pcb_counter.sv
// One event counter with its selector and stream-match storage.
module pcb_counter #(
  parameter int CTR_W  = 32,
  parameter int NUM_EV = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_evt,
  input  logic              wr_smr,
  input  logic [31:0]       wdata,
  input  logic              count_on,
  input  logic [NUM_EV-1:0] evt_i,
  output logic [CTR_W-1:0]  value,
  output logic [15:0]       evt_sel,
  output logic [31:0]       smr,
  output logic              wrap_o
);
  logic             bump;
  logic             written;
  logic [CTR_W-1:0] nxt;

  // Event 0 is every cycle; k in 1..NUM_EV follows strobe k-1.
  function automatic logic ev_hit(input logic [15:0] sel, input logic [NUM_EV-1:0] ev);
    logic h;
    h = (sel == 16'd0);
    for (int k = 1; k <= NUM_EV; k++) begin
      if (sel == 16'(k)) h = ev[k-1];
    end
    return h;
  endfunction

  // Replace one 32-bit half of the counter.
  function automatic logic [CTR_W-1:0] merge_word(input logic [CTR_W-1:0] cur,
                                                  input logic [31:0] w, input logic hi);
    logic [63:0] t;
    t = 64'(cur);
    if (hi) t[63:32] = w;
    else    t[31:0]  = w;
    return t[CTR_W-1:0];
  endfunction

  always_comb begin
    bump    = count_on & ev_hit(evt_sel, evt_i);
    written = wr_lo | wr_hi;
    wrap_o  = bump & ~written & (&value);
    nxt     = value;
    if (written)   nxt = merge_word(value, wdata, wr_hi);
    else if (bump) nxt = value + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      evt_sel <= '0;
      smr     <= '0;
    end else begin
      value <= nxt;
      if (wr_evt) evt_sel <= wdata[15:0];
      if (wr_smr) smr     <= wdata;
    end
  end
endmodule

// File: rtl/pcb_irq.sv
// Interrupt combine: any overflowed and enabled counter, gated by the output enable.
module pcb_irq #(
  parameter int NUM_CTR = 4
) (
  input  logic [NUM_CTR-1:0] ovf,
  input  logic [NUM_CTR-1:0] ien,
  input  logic               out_en,
  output logic               irq
);
  assign irq = out_en & (|(ovf & ien));
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank import pcb_pkg::*; #(
  parameter int NUM_CTR       = 4,
  parameter int CTR_W         = 32,
  parameter int NUM_EV        = 7,
  parameter bit GLOBAL_FILTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [NUM_EV-1:0] evt_i,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq_o
);
  localparam bit WIDE  = (CTR_W > 32);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  dec_t               dec;
  logic               wr;
  logic               rd_req;
  logic               idx_ok;
  logic [NUM_CTR-1:0] wmask;
  logic [NUM_CTR-1:0] cen_q, ien_q, ovf_q;
  logic [NUM_CTR-1:0] cen_set, cen_clr, ien_set, ien_clr, ovf_set, ovf_clr;
  logic [NUM_CTR-1:0] wrap_vec;
  logic               glb_en_q, irq_en_q;
  logic               cnt_wr_any;
  logic [BUS_W-1:0]   rdata_c;
  logic [CTR_W-1:0]   cnt_val [NUM_CTR];
  logic [15:0]        evt_sel [NUM_CTR];
  logic [31:0]        smr_val [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  function automatic logic [31:0] word_of(input logic [CTR_W-1:0] v, input logic hi);
    logic [63:0] t;
    t = 64'(v);
    return hi ? t[63:32] : t[31:0];
  endfunction

  function automatic logic [31:0] cfg_word();
    logic [31:0] c;
    c        = '0;
    c[5:0]   = 6'(NUM_CTR - 1);
    c[13:8]  = 6'(CTR_W - 1);
    c[23]    = GLOBAL_FILTER;
    return c;
  endfunction

  assign dec        = decode_addr(req_addr, WIDE);
  assign wr         = req_valid & req_write;
  assign rd_req     = req_valid & ~req_write;
  assign idx_ok     = (dec.idx < 8'(NUM_CTR));
  assign wmask      = req_wdata[NUM_CTR-1:0];
  assign cnt_wr_any = wr & idx_ok & ((dec.kind == K_CNT_LO) | (dec.kind == K_CNT_HI));

  assign cen_set = (wr && dec.kind == K_CEN_SET) ? wmask : '0;
  assign cen_clr = (wr && dec.kind == K_CEN_CLR) ? wmask : '0;
  assign ien_set = (wr && dec.kind == K_IEN_SET) ? wmask : '0;
  assign ien_clr = (wr && dec.kind == K_IEN_CLR) ? wmask : '0;
  assign ovf_set = wrap_vec | ((wr && dec.kind == K_OVF_SET) ? wmask : '0);
  assign ovf_clr = (wr && dec.kind == K_OVF_CLR) ? wmask : '0;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic sel;
    assign sel = wr && (dec.idx == 8'(n));
    pcb_counter #(.CTR_W(CTR_W), .NUM_EV(NUM_EV)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (sel && dec.kind == K_CNT_LO),
      .wr_hi    (sel && dec.kind == K_CNT_HI),
      .wr_evt   (sel && dec.kind == K_EVT),
      .wr_smr   (sel && dec.kind == K_SMR),
      .wdata    (req_wdata),
      .count_on (glb_en_q & cen_q[n]),
      .evt_i    (evt_i),
      .value    (cnt_val[n]),
      .evt_sel  (evt_sel[n]),
      .smr      (smr_val[n]),
      .wrap_o   (wrap_vec[n])
    );
    assign cnt_flat[n*CTR_W +: CTR_W] = cnt_val[n];
  end

  pcb_setclr #(.W(NUM_CTR)) u_cen (.clk(clk), .rst_n(rst_n), .set_mask(cen_set), .clr_mask(cen_clr), .q(cen_q));
  pcb_setclr #(.W(NUM_CTR)) u_ien (.clk(clk), .rst_n(rst_n), .set_mask(ien_set), .clr_mask(ien_clr), .q(ien_q));
  pcb_setclr #(.W(NUM_CTR)) u_ovf (.clk(clk), .rst_n(rst_n), .set_mask(ovf_set), .clr_mask(ovf_clr), .q(ovf_q));

  pcb_irq #(.NUM_CTR(NUM_CTR)) u_irq (.ovf(ovf_q), .ien(ien_q), .out_en(irq_en_q), .irq(irq_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr && dec.kind == K_RUN)    glb_en_q <= req_wdata[0];
      if (wr && dec.kind == K_IRQCTL) irq_en_q <= req_wdata[0];
    end
  end

  always_comb begin
    rdata_c = '0;
    case (dec.kind)
      K_CNT_LO:             if (idx_ok) rdata_c = word_of(cnt_val[dec.idx[IDX_W-1:0]], 1'b0);
      K_CNT_HI:             if (idx_ok) rdata_c = word_of(cnt_val[dec.idx[IDX_W-1:0]], 1'b1);
      K_EVT:                if (idx_ok) rdata_c = 32'(evt_sel[dec.idx[IDX_W-1:0]]);
      K_SMR:                if (idx_ok) rdata_c = smr_val[dec.idx[IDX_W-1:0]];
      K_CEN_SET, K_CEN_CLR: rdata_c = 32'(cen_q);
      K_IEN_SET, K_IEN_CLR: rdata_c = 32'(ien_q);
      K_OVF_SET, K_OVF_CLR: rdata_c = 32'(ovf_q);
      K_CFG:                rdata_c = cfg_word();
      K_RUN:                rdata_c = 32'(glb_en_q);
      K_IRQCTL:             rdata_c = 32'(irq_en_q);
      default:              rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rdata_c;
    end
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     rd_valid,
  input logic                     irq_o,
  input logic                     glb_en_q,
  input logic                     irq_en_q,
  input logic                     cnt_wr_any,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       ien_q,
  input logic [NUM_CTR-1:0]       wrap_vec,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  p_read_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  p_no_spurious_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  p_frozen_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_q && !cnt_wr_any) |=> $stable(cnt_flat));

  p_wrap_sets_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq_o);

  p_irq_needs_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q & ien_q) == '0) |-> !irq_o);
endmodule

bind perf_cnt_bank pcb_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_pcb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rd_valid   (rd_valid),
  .irq_o      (irq_o),
  .glb_en_q   (glb_en_q),
  .irq_en_q   (irq_en_q),
  .cnt_wr_any (cnt_wr_any),
  .ovf_q      (ovf_q),
  .ien_q      (ien_q),
  .wrap_vec   (wrap_vec),
  .cnt_flat   (cnt_flat)
);

// File: tb/perf_cnt_bank_bench.sv
module perf_cnt_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 40;
  localparam int NE = 3;
  localparam bit GF = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [NE-1:0] evt_i = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_cnt_bank #(.NUM_CTR(NC), .CTR_W(CW), .NUM_EV(NE), .GLOBAL_FILTER(GF)) u_perf_cnt_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .evt_i(evt_i),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  logic [7:0] lfsr = 8'h5A;

  // Behavioural reference state
  longint unsigned m_cnt [NC];
  int unsigned     m_evt [NC];
  int unsigned     m_smr [NC];
  int unsigned     m_cen = 0, m_ien = 0, m_ovf = 0;
  bit              m_run = 0, m_ictl = 0;
  bit              exp_rv = 0;
  int unsigned     exp_rd = 0;
  localparam longint unsigned CMASK = (64'd1 << CW) - 1;
  localparam int unsigned     NMASK = (1 << NC) - 1;

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = 0; m_evt[i] = 0; m_smr[i] = 0;
    end
  end

  function automatic void check(string what, longint unsigned act, longint unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
    end
  endfunction

  function automatic bit m_hit(int unsigned sel, logic [NE-1:0] e);
    if (sel == 0) return 1'b1;
    if (sel <= NE) return e[sel-1];
    return 1'b0;
  endfunction

  function automatic int unsigned mread(int unsigned ai);
    int unsigned n;
    if (ai < 'h400) begin
      n = ai / 8;
      if (n >= NC) return 0;
      if ((ai % 8) == 4) return int'(m_cnt[n] >> 32);
      return int'(m_cnt[n] & 64'hFFFF_FFFF);
    end
    if (ai < 'h800) begin
      n = (ai - 'h400) / 4;
      return (n < NC) ? m_evt[n] : 0;
    end
    if (ai >= 'hA00 && ai < 'hC00) begin
      n = (ai - 'hA00) / 4;
      return (n < NC) ? m_smr[n] : 0;
    end
    case (ai)
      'hC00, 'hC20: return m_cen;
      'hC40, 'hC60: return m_ien;
      'hC80, 'hCC0: return m_ovf;
      'hE00:        return (NC - 1) | ((CW - 1) << 8) | (int'(GF) << 23);
      'hE04:        return int'(m_run);
      'hE50:        return int'(m_ictl);
      default:      return 0;
    endcase
  endfunction

  function automatic void model_edge(bit v, bit w, int unsigned ai, int unsigned d, logic [NE-1:0] e);
    int unsigned wraps = 0;
    bit wr = v && w;
    exp_rv = v && !w;
    if (exp_rv) exp_rd = mread(ai);
    for (int n = 0; n < NC; n++) begin
      bit cw = wr && ai < 'h400 && (ai / 8) == n;
      if (cw) begin
        if ((ai % 8) == 4) m_cnt[n] = ((longint'(d) << 32) | (m_cnt[n] & 64'hFFFF_FFFF)) & CMASK;
        else               m_cnt[n] = (m_cnt[n] & ~64'hFFFF_FFFF) | longint'(d);
      end else if (m_run && m_cen[n] && m_hit(m_evt[n], e)) begin
        if (m_cnt[n] == CMASK) begin
          m_cnt[n] = 0;
          wraps |= (1 << n);
        end else m_cnt[n] = m_cnt[n] + 1;
      end
    end
    if (wr) begin
      if (ai >= 'h400 && ai < 'h800 && (ai - 'h400) / 4 < NC) m_evt[(ai - 'h400) / 4] = d & 'hFFFF;
      if (ai >= 'hA00 && ai < 'hC00 && (ai - 'hA00) / 4 < NC) m_smr[(ai - 'hA00) / 4] = d;
      case (ai)
        'hC00: m_cen = m_cen | (d & NMASK);
        'hC20: m_cen = m_cen & ~d;
        'hC40: m_ien = m_ien | (d & NMASK);
        'hC60: m_ien = m_ien & ~d;
        'hC80: m_ovf = m_ovf & ~d;
        'hCC0: m_ovf = m_ovf | (d & NMASK);
        'hE04: m_run = d[0];
        'hE50: m_ictl = d[0];
        default: ;
      endcase
    end
    m_ovf = m_ovf | wraps;
  endfunction

  task automatic step(input bit v, input bit w, input int unsigned a, input int unsigned d);
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_valid = v;
    req_write = w;
    req_addr  = 12'(a);
    req_wdata = d;
    evt_i     = lfsr[NE-1:0];
    @(posedge clk);
    model_edge(v, w, a & 'hFFC, d, lfsr[NE-1:0]);
    #1;
    check("irq_o", irq_o, m_ictl && ((m_ovf & m_ien) != 0));
    check("rd_valid", rd_valid, exp_rv);
    if (exp_rv) check($sformatf("rd_data@0x%0h", a), rd_data, exp_rd);
    @(negedge clk);
  endtask

  task automatic wr(input int unsigned a, input int unsigned d); step(1, 1, a, d); endtask
  task automatic rd(input int unsigned a);                       step(1, 0, a, 0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    check("irq_o in reset", irq_o, 0);
    check("rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    // R1: reset values through the bus
    rd('h000); rd('h004); rd('h400); rd('hA00);
    rd('hC00); rd('hC40); rd('hCC0); rd('hE04); rd('hE50);
    cur_req = "R9";  rd('hE00);
    cur_req = "R12"; wr('hE04, 'hFFFF_FFFE); rd('hE04);
    wr('hE50, 'hFFFF_FFFF); rd('hE50); wr('hE50, 0); rd('hE50);
    cur_req = "R10"; wr('hA04, 'hDEAD_BEEF); rd('hA04); rd('hA00);
    cur_req = "R11"; wr('hA10, 'h1234); rd('hA10); wr('h020, 'h55); rd('h020);
    rd('h900); rd('hF00);
    cur_req = "R4";
    wr('h400, 0); wr('h404, 1); wr('h408, 3); wr('h40C, 'hABCD_1234); rd('h40C);
    cur_req = "R11"; wr('h410, 7); rd('h410);
    cur_req = "R6";
    wr('hC00, 'hFFFF_FFFF); rd('hC20); wr('hC20, 'h2); rd('hC00);
    wr('hC40, 'h5); wr('hC60, 'h4); rd('hC40);
    cur_req = "R3";
    wr('hE04, 1); idle(20);
    rd('h000); rd('h008); rd('h010); rd('h018);
    wr('hC00, 'h2); idle(10); rd('h008);
    cur_req = "R4"; idle(15); rd('h010); rd('h008); rd('h018);
    cur_req = "R5";
    wr('h000, 'hFFFF_FFFC); wr('h004, 'hFF); rd('h004); rd('h000);
    cur_req = "R7"; idle(6); rd('hCC0); rd('hC80); rd('h004);
    cur_req = "R8"; wr('hE50, 1); idle(2); wr('hE50, 0); idle(1); wr('hE50, 1);
    cur_req = "R7"; wr('hC80, 1); rd('hCC0);
    cur_req = "R8"; wr('hCC0, 4); idle(1); wr('hC40, 4); idle(1); wr('hC80, 'hFFFF_FFFF); idle(1);
    cur_req = "R7";
    wr('h004, 'hFF); wr('h000, 'hFFFF_FFFE); idle(1); wr('hC80, 1); rd('hCC0);
    cur_req = "R5"; wr('h000, 'h10); rd('h000); rd('h000);
    cur_req = "R3"; wr('hE04, 0); idle(5); rd('h000); rd('h008); rd('h010);
    cur_req = "R10"; wr('hA08, 0); wr('hE04, 1); idle(4); rd('h010); rd('hA08);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule